// File: doc/BRIEF.md
# Software Trap Vector Unit

This unit carries out the program-flow side of a software interrupt in a small CPU with 16-bit addresses. When a trap is requested, it forms the address of an interrupt table entry. The upper byte of that address is an 8-bit base register. The rest is the 6-bit trap vector followed by two zero bits, so each of the 64 entries owns a four-word slot. On the same clock edge the unit does three things: it loads that address into the program counter, it saves the address of the instruction after the trap on a return-address stack, and, if the trap asks for it, it clears the global interrupt enable.

A return request pops the most recent saved address back onto the program counter output. The stack holds twelve entries.
- A push on a full stack overwrites the oldest entry and sets a sticky overflow flag.
- A pop on an empty stack yields address zero and sets a sticky underflow flag.

The enable bit can also be written directly by the CPU. A trap that clears the bit takes priority over that write.

Top module: `trap_vector_unit`

## Requirements
- R1: A trap loads `pcOut` with {`intBase`[7:0], `trapVec`[5:0], 2'b00}. For example, base 8'h3C with vector 21 gives 16'h3C54.
- R2: `pcOut` and a one-cycle `pcLoad` pulse appear right after the rising edge that accepts a trap or return request.
- R3: A trap pushes `nextPc`, and returns pop the saved addresses in last-in, first-out order.
- R4: A trap with `trapClrGie`=1 clears `gie` on its edge. A trap with `trapClrGie`=0 leaves `gie` unchanged.
- R5: `gieLoadEn` writes `gieLoadVal` into `gie` on the next edge. If a trap in the same cycle clears the bit, the clear wins.
- R6: A push onto a stack that already holds 12 entries sets the sticky `stkOverflow` and drops the oldest entry. The 12 newest entries remain poppable.
- R7: A return on an empty stack drives `pcOut` to zero, still pulses `pcLoad`, and sets the sticky `stkUnderflow`.
- R8: When a trap and a return are requested in the same cycle, the trap is performed and the return is ignored, so no entry is popped.
- R9: After reset, `pcOut`=0, `pcLoad`=0, `gie`=0, both flags are 0 and the stack is empty.
- R10: In a cycle with no trap or return request, `pcLoad` is 0 and `pcOut` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| trapReq | input | 1 | Perform a software trap this cycle |
| trapVec | input | 6 | Trap vector number, 0 to 63 |
| trapClrGie | input | 1 | Trap also clears the interrupt enable |
| nextPc | input | 16 | Address of the instruction after the trap |
| intBase | input | 8 | Interrupt table base (upper address byte) |
| retReq | input | 1 | Pop a return address onto the program counter |
| gieLoadEn | input | 1 | Direct write of the interrupt enable |
| gieLoadVal | input | 1 | Value for the direct write |
| pcOut | output | 16 | New program counter value |
| pcLoad | output | 1 | One-cycle strobe: `pcOut` is to be loaded |
| gie | output | 1 | Global interrupt enable |
| stkOverflow | output | 1 | Sticky: a push found the stack full |
| stkUnderflow | output | 1 | Sticky: a pop found the stack empty |

## Verification
Address formation is tried with a table of traps. The table covers all-zero and all-one bases, the lowest and highest vectors, a mid-range vector and single-bit vectors. These values show whether the vector lands in the right bit field and whether the two low bits stay zero.

The same table alternates the enable-clear flag while the enable bit is held at one. Returning through the table in reverse tells LIFO order apart from FIFO order. A run of thirteen traps followed by thirteen returns separates oldest-entry dropping from newest-entry dropping.

Simultaneous trap-and-return and clear-versus-write collisions show which request takes priority.

// File: rtl/trap_pkg.sv
package trap_pkg;
  // Strobes from control to datapath, valid for one cycle.
  typedef struct packed {
    logic push;      // trap: save return address, load target
    logic pop;       // return: load saved address
    logic popEmpty;  // pop found nothing: load zero, leave pointer
    logic clrGie;    // trap clears interrupt enable
    logic ldGie;     // direct enable write
    logic gieVal;    // value for direct write
  } trapStb_t;
endpackage

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter int DEPTH = 12
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     trapReq,
  input  logic     trapClrGie,
  input  logic     retReq,
  input  logic     gieLoadEn,
  input  logic     gieLoadVal,
  output trapStb_t stb,
  output logic     stkOverflow,
  output logic     stkUnderflow
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [CNT_W-1:0] count;

  always_comb begin
    stb = '0;
    if (trapReq) begin
      stb.push   = 1'b1;
      stb.clrGie = trapClrGie;
    end else if (retReq) begin
      stb.pop      = 1'b1;
      stb.popEmpty = (count == '0);
    end
    stb.ldGie  = gieLoadEn && !stb.clrGie;
    stb.gieVal = gieLoadVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count        <= '0;
      stkOverflow  <= 1'b0;
      stkUnderflow <= 1'b0;
    end else if (stb.push) begin
      if (count == FULL) stkOverflow <= 1'b1;
      else               count <= count + 1'b1;
    end else if (stb.pop) begin
      if (count == '0) stkUnderflow <= 1'b1;
      else             count <= count - 1'b1;
    end
  end

  // R6
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    stkOverflow |=> stkOverflow);
  // R6
  overflow_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trapReq && count == FULL) |=> (stkOverflow && count == FULL));
  // R7
  underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    stkUnderflow |=> stkUnderflow);
  // R8
  trap_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trapReq && retReq) |=> (count >= $past(count)));
endmodule

// File: rtl/trap_datapath.sv
module trap_datapath
  import trap_pkg::*;
#(
  parameter int   ADDR_W  = 16,
  parameter int   BASE_W  = 8,
  parameter int   VEC_W   = 6,
  parameter int   DEPTH   = 12,
  parameter logic GIE_RST = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  trapStb_t          stb,
  input  logic [BASE_W-1:0] intBase,
  input  logic [VEC_W-1:0]  trapVec,
  input  logic [ADDR_W-1:0] nextPc,
  output logic [ADDR_W-1:0] pcOut,
  output logic              pcLoad,
  output logic              gie
);
  localparam int SLOT_W = ADDR_W - BASE_W - VEC_W;
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] target;
  logic [ADDR_W-1:0] stkMem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, topPtr, nextPtr;

  // Table address: base, then vector, then zero slot offset.
  generate
    if (SLOT_W > 0) begin : g_slot
      assign target = {intBase, trapVec, {SLOT_W{1'b0}}};
    end else begin : g_noslot
      assign target = {intBase, trapVec};
    end
  endgenerate

  assign topPtr  = (wrPtr == '0)   ? LAST : wrPtr - 1'b1;
  assign nextPtr = (wrPtr == LAST) ? '0   : wrPtr + 1'b1;

  // Circular storage: a push on a full stack overwrites the oldest slot.
  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
      always_ff @(posedge clk) begin
        if (stb.push && wrPtr == PTR_W'(i)) stkMem[i] <= nextPc;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      pcOut  <= '0;
      pcLoad <= 1'b0;
      gie    <= GIE_RST;
    end else begin
      pcLoad <= stb.push || stb.pop;
      if (stb.push) begin
        pcOut <= target;
        wrPtr <= nextPtr;
      end else if (stb.pop) begin
        if (stb.popEmpty) pcOut <= '0;
        else begin
          pcOut <= stkMem[topPtr];
          wrPtr <= topPtr;
        end
      end
      if (stb.clrGie)     gie <= 1'b0;
      else if (stb.ldGie) gie <= stb.gieVal;
    end
  end

  // R2
  pc_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.push || stb.pop) |=> pcLoad);
  // R10
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.push || stb.pop) |=> (!pcLoad && $stable(pcOut)));
  // R1
  trap_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.push |=> (pcOut[ADDR_W-1 -: BASE_W] == $past(intBase)));
  // R4
  gie_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrGie |=> !gie);
  // R7
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.popEmpty |=> (pcOut == '0));
endmodule

// File: rtl/trap_vector_unit.sv
module trap_vector_unit
  import trap_pkg::*;
#(
  parameter int   ADDR_W  = 16,
  parameter int   BASE_W  = 8,
  parameter int   VEC_W   = 6,
  parameter int   DEPTH   = 12,
  parameter logic GIE_RST = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trapReq,
  input  logic [VEC_W-1:0]  trapVec,
  input  logic              trapClrGie,
  input  logic [ADDR_W-1:0] nextPc,
  input  logic [BASE_W-1:0] intBase,
  input  logic              retReq,
  input  logic              gieLoadEn,
  input  logic              gieLoadVal,
  output logic [ADDR_W-1:0] pcOut,
  output logic              pcLoad,
  output logic              gie,
  output logic              stkOverflow,
  output logic              stkUnderflow
);
  trapStb_t stb;

  trap_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .trapReq(trapReq), .trapClrGie(trapClrGie),
    .retReq(retReq), .gieLoadEn(gieLoadEn), .gieLoadVal(gieLoadVal),
    .stb(stb), .stkOverflow(stkOverflow), .stkUnderflow(stkUnderflow)
  );

  trap_datapath #(
    .ADDR_W(ADDR_W), .BASE_W(BASE_W), .VEC_W(VEC_W),
    .DEPTH(DEPTH), .GIE_RST(GIE_RST)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .intBase(intBase),
    .trapVec(trapVec), .nextPc(nextPc),
    .pcOut(pcOut), .pcLoad(pcLoad), .gie(gie)
  );
endmodule

// File: tb/trap_vector_unit_bench.sv
module trap_vector_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {intBase, trapVec, trapClrGie, nextPc}
  localparam logic [30:0] VEC_TBL [NVEC] = '{
    {8'h00, 6'd0,  1'b0, 16'h0101},
    {8'hA5, 6'd63, 1'b0, 16'h2222},
    {8'h3C, 6'd21, 1'b1, 16'h3334},
    {8'hFF, 6'd63, 1'b1, 16'hFFFF},
    {8'h12, 6'd32, 1'b0, 16'h0000},
    {8'h80, 6'd1,  1'b1, 16'h7FFE}
  };

  logic clk = 0, rstN = 0;
  logic trapReq = 0, trapClrGie = 0, retReq = 0, gieLoadEn = 0, gieLoadVal = 0;
  logic [5:0] trapVec = '0;
  logic [15:0] nextPc = '0;
  logic [7:0] intBase = '0;
  logic [15:0] pcOut;
  logic pcLoad, gie, stkOverflow, stkUnderflow;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_vector_unit u_trap_vector_unit (
    .clk(clk), .rstN(rstN), .trapReq(trapReq), .trapVec(trapVec),
    .trapClrGie(trapClrGie), .nextPc(nextPc), .intBase(intBase),
    .retReq(retReq), .gieLoadEn(gieLoadEn), .gieLoadVal(gieLoadVal),
    .pcOut(pcOut), .pcLoad(pcLoad), .gie(gie),
    .stkOverflow(stkOverflow), .stkUnderflow(stkUnderflow)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at negedge, let one rising edge pass, sample 1 time unit later.
  task automatic step(input logic tr, input logic [7:0] b, input logic [5:0] v,
                      input logic c, input logic [15:0] np, input logic rt,
                      input logic le, input logic lv);
    @(negedge clk);
    trapReq = tr; intBase = b; trapVec = v; trapClrGie = c; nextPc = np;
    retReq = rt; gieLoadEn = le; gieLoadVal = lv;
    @(posedge clk); #1;
    trapReq = 0; retReq = 0; gieLoadEn = 0; trapClrGie = 0;
  endtask

  task automatic doReset();
    rstN = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); rstN = 1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] exp;
    logic [15:0] held;
    doReset();
    // R9 reset state
    chk("R9 pcOut", pcOut, 16'h0);
    chk("R9 pcLoad", {15'b0, pcLoad}, 16'h0);
    chk("R9 gie", {15'b0, gie}, 16'h0);
    chk("R9 ovf", {15'b0, stkOverflow}, 16'h0);
    chk("R9 unf", {15'b0, stkUnderflow}, 16'h0);

    // Table walk: R1, R2, R4, R5
    for (int i = 0; i < NVEC; i++) begin
      step(0, 0, 0, 0, 0, 0, 1, 1);
      chk("R5 gie load", {15'b0, gie}, 16'h1);
      step(1, VEC_TBL[i][30:23], VEC_TBL[i][22:17], VEC_TBL[i][16], VEC_TBL[i][15:0], 0, 0, 0);
      exp = {VEC_TBL[i][30:23], VEC_TBL[i][22:17], 2'b00};
      chk("R1 target", pcOut, exp);
      chk("R2 pcLoad", {15'b0, pcLoad}, 16'h1);
      chk("R4 gie after trap", {15'b0, gie}, VEC_TBL[i][16] ? 16'h0 : 16'h1);
    end
    // R10 idle cycle
    held = pcOut;
    step(0, 8'h55, 6'd7, 0, 16'h1234, 0, 0, 0);
    chk("R10 pcLoad", {15'b0, pcLoad}, 16'h0);
    chk("R10 pcOut hold", pcOut, held);
    // R3 returns in reverse order
    for (int i = NVEC - 1; i >= 0; i--) begin
      step(0, 0, 0, 0, 0, 1, 0, 0);
      chk("R3 pop order", pcOut, VEC_TBL[i][15:0]);
      chk("R2 pcLoad on pop", {15'b0, pcLoad}, 16'h1);
    end
    chk("R7 no unf yet", {15'b0, stkUnderflow}, 16'h0);
    // R7 empty pop
    step(0, 0, 0, 0, 0, 1, 0, 0);
    chk("R7 empty pcOut", pcOut, 16'h0);
    chk("R7 empty pcLoad", {15'b0, pcLoad}, 16'h1);
    chk("R7 unf", {15'b0, stkUnderflow}, 16'h1);

    // R6 overflow
    doReset();
    for (int i = 0; i < 12; i++) step(1, 8'h01, 6'(i), 0, 16'h1000 + 16'(i), 0, 0, 0);
    chk("R6 no ovf at 12", {15'b0, stkOverflow}, 16'h0);
    step(1, 8'h01, 6'd12, 0, 16'h100C, 0, 0, 0);
    chk("R6 ovf", {15'b0, stkOverflow}, 16'h1);
    for (int i = 12; i >= 1; i--) begin
      step(0, 0, 0, 0, 0, 1, 0, 0);
      chk("R6 newest kept", pcOut, 16'h1000 + 16'(i));
    end
    chk("R6 no unf after 12 pops", {15'b0, stkUnderflow}, 16'h0);
    step(0, 0, 0, 0, 0, 1, 0, 0);
    chk("R6 oldest dropped", pcOut, 16'h0);
    chk("R7 unf after drop", {15'b0, stkUnderflow}, 16'h1);
    step(1, 8'h02, 6'd0, 0, 16'hABCD, 0, 0, 0);
    chk("R6 ovf sticky", {15'b0, stkOverflow}, 16'h1);

    // R8 trap wins over return; R5 clear beats load
    doReset();
    step(1, 8'h10, 6'd2, 0, 16'hAAAA, 0, 0, 0);
    step(1, 8'h20, 6'd3, 1, 16'hBBBB, 1, 1, 1);
    chk("R8 trap target", pcOut, 16'h200C);
    chk("R5 clear wins", {15'b0, gie}, 16'h0);
    step(0, 0, 0, 0, 0, 1, 0, 0);
    chk("R8 first pop", pcOut, 16'hBBBB);
    step(0, 0, 0, 0, 0, 1, 0, 0);
    chk("R8 second pop", pcOut, 16'hAAAA);
    chk("R8 no unf", {15'b0, stkUnderflow}, 16'h0);
    // R5 direct clear
    step(0, 0, 0, 0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 0, 0, 1, 0);
    chk("R5 load zero", {15'b0, gie}, 16'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule